// File: doc/BRIEF.md
# Synchronous Memory and IO Responder

This block answers bus requests from an 8-bit processor core whose bus is fully synchronous to one clock. Each cycle the core may present a 16-bit address, a byte of write data and three strobes (IO select, read, write), all qualified by a single valid signal. The responder sorts every valid access into one of two spaces.

The memory space is a small inferred RAM. The IO space is a handful of registered byte-wide output ports, and their contents appear on a flat output bus. Reads are registered: the byte picked on the request edge is driven back to the core during the whole next cycle. The core captures it on the edge that closes that cycle. The byte then stays put until another read is accepted.

Top module: `sync_bus_slave`

## Requirements
- R1: While `rst` is high on a rising edge, every IO port register is cleared to 0x00 and `bus_rdata` reads 0x00 from the following cycle; memory contents are not initialised.
- R2: On a rising edge where `bus_valid`, `bus_wr` are high and `bus_io` is low, `bus_wdata` is stored at memory word `bus_addr[MEM_AW-1:0]`; the IO ports are unchanged.
- R3: On a rising edge where `bus_valid` and `bus_rd` are high, the selected byte appears on `bus_rdata` right after that edge and stays there until the next accepted read, including back-to-back reads.
- R4: While `bus_valid` is low, the address, data and strobes have no effect: memory, the IO ports and `bus_rdata` keep their values.
- R5: On a rising edge where `bus_valid`, `bus_wr`, `bus_io` are high, `bus_addr[15:8]` is 0x00 and `bus_addr[7:0]` is less than `NUM_PORTS`, port number `bus_addr[7:0]` takes `bus_wdata` and shows it on `port_q[8*n +: 8]`; memory is unchanged. An IO read of such a port returns its current value.
- R6: An IO access whose upper address byte is not 0x00 selects no port: a write changes nothing and a read returns 0xFF.
- R7: An IO access to a low address byte at or above `NUM_PORTS` is unmapped: a write changes nothing and a read returns 0xFF.
- R8: A valid access with neither `bus_rd` nor `bus_wr` high changes no storage and leaves `bus_rdata` as it was.
- R9: Memory decodes only the low `MEM_AW` address bits, so addresses that differ only above them reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Qualifies every other bus input for this cycle |
| bus_io | input | 1 | High selects IO space, low selects memory |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | 16 | Byte address; upper byte 0x00 for IO |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data returned to the core |
| port_q | output | 8*NUM_PORTS | IO port registers, port n in bits [8n+7:8n] |

## Verification
The awkward case is an access that looks real in every field except the one that should cancel it: a write with valid low, an IO write carrying a nonzero upper byte, or a valid cycle with neither strobe. From the ports these show nothing unless the stored state is read back afterwards. The stimulus therefore plants known bytes in memory and ports first, fires each cancelled access at those same locations, and then reads them back or inspects `port_q`. It also interleaves idle cycles and back-to-back reads so that the holding of `bus_rdata` is observed across both.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int unsigned BUS_AW = 16;
    localparam int unsigned BUS_DW = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MEM  = 2'd1,
        SEL_IO   = 2'd2
    } rsel_e;

    typedef struct packed {
        logic mem_we;
        logic mem_re;
        logic io_we;
        logic io_re;
        logic io_hit;
    } strobe_t;

    function automatic logic io_port_hit(input logic [BUS_AW-1:0] a,
                                         input int unsigned n_ports);
        return (a[BUS_AW-1:8] == '0) && (32'(a[7:0]) < n_ports);
    endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic              valid,
    input  logic              io,
    input  logic              rd,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    output strobe_t           stb
);
    always_comb begin
        stb.mem_we = valid & wr & ~io;
        stb.mem_re = valid & rd & ~io;
        stb.io_we  = valid & wr & io;
        stb.io_re  = valid & rd & io;
        stb.io_hit = io_port_hit(addr, NUM_PORTS);
    end
endmodule

// File: rtl/sbs_ram.sv
module sbs_ram
    import sbs_pkg::*;
#(
    parameter int unsigned MEM_AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [MEM_AW-1:0] idx,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] q
);
    localparam int unsigned DEPTH = 1 << MEM_AW;

    logic [BUS_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
        if (re) begin
            q <= mem[idx];
        end
    end
endmodule

// File: rtl/sbs_ports.sv
module sbs_ports
    import sbs_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic                        re,
    input  logic                        hit,
    input  logic [$clog2(NUM_PORTS)-1:0] idx,
    input  logic [BUS_DW-1:0]           wdata,
    output logic [BUS_DW-1:0]           q,
    output logic [BUS_DW*NUM_PORTS-1:0] port_q
);
    localparam logic [BUS_DW-1:0] UNMAPPED = '1;

    logic [BUS_DW-1:0] regs [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NUM_PORTS); i++) begin
                regs[i] <= '0;
            end
            q <= '0;
        end else begin
            if (we && hit) begin
                regs[idx] <= wdata;
            end
            if (re) begin
                q <= hit ? regs[idx] : UNMAPPED;
            end
        end
    end

    for (genvar g = 0; g < int'(NUM_PORTS); g++) begin : g_port
        assign port_q[g*BUS_DW +: BUS_DW] = regs[g];
    end
endmodule

// File: rtl/sync_bus_slave.sv
module sync_bus_slave
    import sbs_pkg::*;
#(
    parameter int unsigned MEM_AW    = 8,
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_valid,
    input  logic                        bus_io,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [15:0]                 bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    output logic [8*NUM_PORTS-1:0]      port_q
);
    localparam int unsigned PIW = $clog2(NUM_PORTS);

    strobe_t     stb;
    rsel_e       sel_q;
    logic [7:0]  ram_q;
    logic [7:0]  io_q;

    sbs_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .valid (bus_valid),
        .io    (bus_io),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .stb   (stb)
    );

    sbs_ram #(.MEM_AW(MEM_AW)) u_ram (
        .clk   (clk),
        .we    (stb.mem_we),
        .re    (stb.mem_re),
        .idx   (bus_addr[MEM_AW-1:0]),
        .wdata (bus_wdata),
        .q     (ram_q)
    );

    sbs_ports #(.NUM_PORTS(NUM_PORTS)) u_ports (
        .clk    (clk),
        .rst    (rst),
        .we     (stb.io_we),
        .re     (stb.io_re),
        .hit    (stb.io_hit),
        .idx    (bus_addr[PIW-1:0]),
        .wdata  (bus_wdata),
        .q      (io_q),
        .port_q (port_q)
    );

    // Remember which space answered the last accepted read.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_NONE;
        end else if (stb.mem_re) begin
            sel_q <= SEL_MEM;
        end else if (stb.io_re) begin
            sel_q <= SEL_IO;
        end
    end

    always_comb begin
        case (sel_q)
            SEL_MEM: bus_rdata = ram_q;
            SEL_IO:  bus_rdata = io_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int unsigned NUM_PORTS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_valid,
    input logic                   bus_io,
    input logic                   bus_rd,
    input logic                   bus_wr,
    input logic [15:0]            bus_addr,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [8*NUM_PORTS-1:0] port_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (port_q == '0) && (bus_rdata == 8'h00));

    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_rd) |=> $stable(bus_rdata));

    p_idle_bus_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> $stable(port_q) && $stable(bus_rdata));

    p_port_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_wr && bus_io) |=> $stable(port_q));

    p_port0_write_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_wr && bus_io && bus_addr == 16'h0000)
        |=> port_q[7:0] == $past(bus_wdata));

    p_high_byte_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_rd && bus_io && bus_addr[15:8] != 8'h00)
        |=> bus_rdata == 8'hFF);

    p_unmapped_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_rd && bus_io && 32'(bus_addr[7:0]) >= NUM_PORTS)
        |=> bus_rdata == 8'hFF);
endmodule

bind sync_bus_slave sbs_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_io    (bus_io),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_q    (port_q)
);

// File: tb/sim_sync_bus_slave.sv
module sim_sync_bus_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_io = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [8*NP-1:0] port_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_bus_slave #(.MEM_AW(8), .NUM_PORTS(NP)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_io(bus_io),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_q(port_q)
    );

    // Monitor: each queued item belongs to the cycle after its request edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: bus_rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic drive(input logic v, input logic io, input logic rd,
                         input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = v; bus_io = io; bus_rd = rd; bus_wr = wr;
        bus_addr = a; bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic expect_rd(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic rd_mem(input logic [15:0] a, input logic [7:0] e, input string t);
        drive(1'b1, 1'b0, 1'b1, 1'b0, a, 8'h00);
        expect_rd(e, t);
    endtask

    task automatic rd_io(input logic [15:0] a, input logic [7:0] e, input string t);
        drive(1'b1, 1'b1, 1'b1, 1'b0, a, 8'h00);
        expect_rd(e, t);
    endtask

    task automatic idle(input logic [7:0] e, input string t);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00);
        expect_rd(e, t);
    endtask

    task automatic check_ports(input logic [8*NP-1:0] e, input string t);
        @(negedge clk);
        bus_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_io = 1'b0;
        checks++;
        if (port_q !== e) begin
            errors++;
            $display("FAIL %s: port_q actual %h expected %h", t, port_q, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_ports('0, "R1 ports cleared");
        checks++;
        if (bus_rdata !== 8'h00) begin
            errors++;
            $display("FAIL R1: bus_rdata actual %h expected 00", bus_rdata);
        end

        // R2 / R3: memory write, read, hold, back-to-back
        drive(1'b1, 1'b0, 1'b0, 1'b1, 16'h0010, 8'h3C);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 16'h0011, 8'hA5);
        rd_mem(16'h0010, 8'h3C, "R2 read 0x10");
        idle(8'h3C, "R3 hold one");
        idle(8'h3C, "R3 hold two");
        rd_mem(16'h0011, 8'hA5, "R3 b2b first");
        rd_mem(16'h0010, 8'h3C, "R3 b2b second");
        rd_mem(16'h0011, 8'hA5, "R3 b2b third");

        // R5: IO write, readback, isolation from memory
        drive(1'b1, 1'b0, 1'b0, 1'b1, 16'h0002, 8'h77);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h0002, 8'h5A);
        check_ports(32'h005A_0000, "R5 port2 written");
        rd_io(16'h0002, 8'h5A, "R5 port2 readback");
        rd_mem(16'h0002, 8'h77, "R5 memory untouched by IO write");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 8'hC3);
        check_ports(32'h005A_00C3, "R5 port0 written");
        drive(1'b1, 1'b0, 1'b0, 1'b1, 16'h0003, 8'h12);
        check_ports(32'h005A_00C3, "R2 memory write leaves ports");

        // R9: aliasing above MEM_AW
        drive(1'b1, 1'b0, 1'b0, 1'b1, 16'h0105, 8'h99);
        rd_mem(16'h0005, 8'h99, "R9 alias low");
        rd_mem(16'hFF05, 8'h99, "R9 alias high");

        // R6: IO with nonzero upper byte
        drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h0100, 8'hEE);
        check_ports(32'h005A_00C3, "R6 write ignored");
        rd_io(16'h0102, 8'hFF, "R6 read FF");

        // R7: unmapped IO port
        rd_io(16'h0007, 8'hFF, "R7 read FF");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h0004, 8'h11);
        check_ports(32'h005A_00C3, "R7 write ignored");
        rd_io(16'h0000, 8'hC3, "R5 port0 readback");

        // R4: valid low
        drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0010, 8'h00);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 16'h0001, 8'h66);
        check_ports(32'h005A_00C3, "R4 IO write ignored");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h0011, 8'h00);
        expect_rd(8'hC3, "R4 read ignored");
        rd_mem(16'h0010, 8'h3C, "R4 memory write ignored");

        // R8: valid with no strobe
        drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h0001, 8'h44);
        expect_rd(8'h3C, "R8 rdata unchanged");
        check_ports(32'h005A_00C3, "R8 ports unchanged");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h0010, 8'h44);
        expect_rd(8'h3C, "R8 rdata unchanged mem");
        rd_mem(16'h0010, 8'h3C, "R8 memory unchanged");

        // R1: reset in mid-run
        @(negedge clk);
        bus_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_ports('0, "R1 ports cleared again");
        checks++;
        if (bus_rdata !== 8'h00) begin
            errors++;
            $display("FAIL R1: bus_rdata actual %h expected 00", bus_rdata);
        end

        repeat (2) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule